// File: doc/BRIEF.md
# I2C Single-Byte Master

This block is the controller side of a two-wire, open-drain serial bus. One command pulse makes it run a complete single-byte transaction with a slave that has a 7-bit address:

- a start condition;
- the address and the direction bit;
- an acknowledge slot;
- one data byte, written or read;
- a second acknowledge slot;
- a stop condition.

When the transaction ends the block raises a one-cycle completion strobe. A read leaves the received byte on its output. A sticky error flag reports when the slave did not acknowledge.

The block never drives either line high. Each line has a pull-enable output: 1 pulls the wire low, and 0 lets the external resistor pull it high. The SDA wire level comes back in through a synchronizer. Every SCL period is split into four equal quarters, with these roles:

| Quarter | SCL | SDA |
|---|---|---|
| q0 | low | may change |
| q1 | high (released) | held |
| q2 | high (released) | held |
| q3 | low | held |

Inputs are sampled at the boundary between q1 and q2, which is the middle of SCL high. The quarter length in system clocks comes from the clock and bus-rate parameters.

Top module: `i2c_byte_master`

## Requirements
- R1: The line outputs are pull enables only: 1 pulls the wire low and 0 releases it. Both are 0 during reset and whenever `busy` is 0.
- R2: A transaction sends, in this order:
  - a start condition;
  - address bits A6 down to A0;
  - a direction bit (1 = read, 0 = write);
  - an acknowledge slot;
  - eight data bits, most significant first;
  - a second acknowledge slot;
  - a stop condition.
- R3: A start is SDA pulled low while SCL is released. A stop is SDA released while SCL is released. The stop includes one SCL low-to-high transition before SDA rises.
- R4: Outside start and stop, SDA changes only in a cycle where SCL was pulled low both before and after the change.
- R5: QUARTER = CLK_HZ/(4*SCL_HZ) system clocks, and one SCL period is 4*QUARTER clocks with SCL high for 2*QUARTER of them. The defaults (40 MHz, 400 kHz) give 100 clocks per period and 50 clocks high.
- R6: If SDA is high in the address acknowledge slot, the following happens:
  - `nack` becomes 1;
  - no data bits are clocked;
  - the stop follows directly.
- R7: On a write, if SDA is high in the second acknowledge slot, `nack` becomes 1 and the stop follows.
- R8: On a read, the master releases SDA during the data bits and during the final slot, so the final slot carries a not-acknowledge. `rd_data` then holds the received byte. `rd_data` is left unchanged by writes and by transactions that fail at the address.
- R9: `done` is a single-cycle pulse in the cycle after the stop completes. `busy` is 1 from the cycle after `cmd_go` until `done`. `nack` holds its value until the next accepted command.
- R10: `cmd_go` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_go | input | 1 | Start-transaction pulse, taken only when idle |
| cmd_addr | input | 7 | Slave address |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_wdata | input | 8 | Byte to send on a write |
| rd_data | output | 8 | Byte received by the last successful read |
| done | output | 1 | One-cycle completion strobe |
| nack | output | 1 | Acknowledge missing in the last transaction |
| busy | output | 1 | Transaction in progress |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA wire level |

## Verification
The bench connects a behavioural open-drain slave and targets these corner cases:

- **Slave that does not answer its address.** A design that ignored the bad acknowledge would clock the data byte anyway, giving nineteen SCL rises instead of ten.
- **Write whose data byte is refused.** This would go unreported if only the address slot were checked.
- **Read.** A master that kept driving SDA would corrupt the slave's byte or acknowledge it instead of ending with a not-acknowledge.
- **Command issued mid-transaction.** A design that took it would emit a second start and address.
- **Measured SCL high time and period.** These catch a divider or quarter-phase assignment that is off by one.

// File: rtl/i2c_bm_pkg.sv
// Shared types for the single-byte two-wire master.
package i2c_bm_pkg;
    // Transaction sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_AACK,
        ST_DATA,
        ST_DACK,
        ST_STOP
    } bm_state_t;
endpackage

// File: rtl/i2c_bm_qtick.sv
// Quarter-phase tick generator.
// Emits a one-cycle tick every DIV clocks while clr is low.
// clr holds the count at zero, so the first tick after clr drops comes
// exactly DIV clocks later.
// Assumes DIV >= 1.
module i2c_bm_qtick #(
    parameter int DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt;

    // Count clocks within one quarter-phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    assign tick = !clr && (cnt == W'(DIV - 1));
endmodule

// File: rtl/i2c_bm_sync.sv
// Multi-flop synchronizer for an asynchronous line level.
// Resets to 1, the released level of a pulled-up wire.
// Assumes STAGES >= 2.
module i2c_bm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    // Shift the sensed level through the stages.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/i2c_byte_master.sv
// Single-byte master for an open-drain two-wire bus.
// Runs start, address with direction, acknowledge, one data byte,
// acknowledge, then stop.
// Only pull-low enables are produced; the lines are never driven high.
// Assumes no other master on the bus and no slave clock stretching.
module i2c_byte_master
    import i2c_bm_pkg::*;
#(
    parameter int CLK_HZ      = 40_000_000,
    parameter int SCL_HZ      = 400_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_go,
    input  logic [6:0] cmd_addr,
    input  logic       cmd_rd,
    input  logic [7:0] cmd_wdata,
    output logic [7:0] rd_data,
    output logic       done,
    output logic       nack,
    output logic       busy,
    output logic       scl_drive_low,
    output logic       sda_drive_low,
    input  logic       sda_in
);
    localparam int QUARTER = (CLK_HZ / (4 * SCL_HZ) > 0) ? CLK_HZ / (4 * SCL_HZ) : 1;
    localparam int BYTE_W  = 8;
    localparam int IDX_W   = $clog2(BYTE_W);

    bm_state_t         state;
    logic [1:0]        phase;
    logic [IDX_W-1:0]  bit_idx;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] rdata_r;
    logic              rd_r;
    logic              nack_r;
    logic              done_r;
    logic              tick;
    logic              sda_s;

    i2c_bm_qtick #(.DIV(QUARTER)) u_qtick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == ST_IDLE),
        .tick  (tick)
    );

    i2c_bm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sda_in),
        .q     (sda_s)
    );

    // Sequencer: accepts commands, steps quarter-phases, samples mid-high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            phase   <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            rdata_r <= '0;
            rd_r    <= 1'b0;
            nack_r  <= 1'b0;
            done_r  <= 1'b0;
        end else begin
            done_r <= 1'b0;
            if (state == ST_IDLE) begin
                if (cmd_go) begin
                    state  <= ST_START;
                    phase  <= '0;
                    shreg  <= {cmd_addr, cmd_rd};
                    rd_r   <= cmd_rd;
                    nack_r <= 1'b0;
                end
            end else if (tick) begin
                phase <= phase + 2'd1;
                if (phase == 2'd1) begin
                    if (state == ST_AACK && sda_s)
                        nack_r <= 1'b1;
                    if (state == ST_DATA && rd_r)
                        rdata_r <= {rdata_r[BYTE_W-2:0], sda_s};
                    if (state == ST_DACK && !rd_r && sda_s)
                        nack_r <= 1'b1;
                end
                if (phase == 2'd3) begin
                    unique case (state)
                        ST_START: begin
                            state   <= ST_ADDR;
                            bit_idx <= IDX_W'(BYTE_W - 1);
                        end
                        ST_ADDR, ST_DATA: begin
                            if (bit_idx == '0) begin
                                state <= (state == ST_ADDR) ? ST_AACK : ST_DACK;
                            end else begin
                                bit_idx <= bit_idx - 1'b1;
                                shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                            end
                        end
                        ST_AACK: begin
                            if (nack_r) begin
                                state <= ST_STOP;
                            end else begin
                                state   <= ST_DATA;
                                shreg   <= cmd_wdata_q;
                                bit_idx <= IDX_W'(BYTE_W - 1);
                            end
                        end
                        ST_DACK: state <= ST_STOP;
                        ST_STOP: begin
                            state  <= ST_IDLE;
                            done_r <= 1'b1;
                        end
                        default: state <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    // Write byte captured with the command.
    logic [BYTE_W-1:0] cmd_wdata_q;

    // Hold the write byte for the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cmd_wdata_q <= '0;
        else if (state == ST_IDLE && cmd_go) cmd_wdata_q <= cmd_wdata;
    end

    // Map state and quarter-phase onto the two pull enables.
    always_comb begin
        scl_drive_low = 1'b0;
        sda_drive_low = 1'b0;
        unique case (state)
            ST_START: begin
                sda_drive_low = phase[1];
                scl_drive_low = (phase == 2'd3);
            end
            ST_ADDR, ST_DATA: begin
                scl_drive_low = (phase == 2'd0) || (phase == 2'd3);
                sda_drive_low = ((state == ST_ADDR) || !rd_r) && !shreg[BYTE_W-1];
            end
            ST_AACK, ST_DACK: begin
                scl_drive_low = (phase == 2'd0) || (phase == 2'd3);
            end
            ST_STOP: begin
                scl_drive_low = (phase == 2'd0);
                sda_drive_low = !phase[1];
            end
            default: ;
        endcase
    end

    assign rd_data = rdata_r;
    assign done    = done_r;
    assign nack    = nack_r;
    assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/i2c_bm_chk.sv
// Protocol checker for i2c_byte_master.
// Bound to every instance of the master.
module i2c_bm_chk
    import i2c_bm_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      scl_pull,
    input logic      sda_pull,
    input logic      busy,
    input logic      done,
    input logic      nack,
    input bm_state_t state
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_pull && !sda_pull)); // R1

    AST_START_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && $rose(sda_pull)) |-> !scl_pull); // R3

    AST_STOP_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && $fell(sda_pull)) |-> !scl_pull); // R3

    AST_SDA_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_pull && !$past(scl_pull) && state != ST_START && state != ST_STOP)
            |-> $stable(sda_pull)); // R4

    AST_NO_DATA_AFTER_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> !nack); // R6

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
endmodule

bind i2c_byte_master i2c_bm_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_pull (scl_drive_low),
    .sda_pull (sda_drive_low),
    .busy     (busy),
    .done     (done),
    .nack     (nack),
    .state    (state)
);

// File: tb/sim_i2c_byte_master.sv
`timescale 1ns/1ps
module sim_i2c_byte_master;
    localparam int TCLK    = 25;
    localparam int QUARTER = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_go = 1'b0;
    logic [6:0] cmd_addr = '0;
    logic       cmd_rd = 1'b0;
    logic [7:0] cmd_wdata = '0;
    logic [7:0] rd_data;
    logic       done, nack, busy, scl_drive_low, sda_drive_low;
    logic       scl_line, sda_line;
    logic       slv_pull = 1'b0;

    int nvec = 0;
    int nfail = 0;

    // Slave model state.
    logic [6:0] slv_addr = 7'h5A;
    logic       slv_ack_addr_en = 1'b1;
    logic       slv_ack_data_en = 1'b1;
    logic [7:0] slv_tx = 8'h96;
    logic       slv_sel = 1'b0;
    logic [7:0] got_abyte = '0;
    logic [7:0] got_dbyte = '0;
    logic       got_mack = 1'b0;
    int         slv_cnt = 0;
    int         starts = 0;
    int         stops = 0;

    always #(TCLK/2.0) clk = ~clk;

    assign scl_line = !scl_drive_low;
    assign sda_line = !(sda_drive_low || slv_pull);

    i2c_byte_master u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_go        (cmd_go),
        .cmd_addr      (cmd_addr),
        .cmd_rd        (cmd_rd),
        .cmd_wdata     (cmd_wdata),
        .rd_data       (rd_data),
        .done          (done),
        .nack          (nack),
        .busy          (busy),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .sda_in        (sda_line)
    );

    // Slave: start detection.
    always @(negedge sda_line) begin
        if (rst_n && scl_line === 1'b1) begin
            starts++;
            slv_cnt = 0;
            slv_pull = 1'b0;
            slv_sel = 1'b0;
        end
    end

    // Slave: stop detection.
    always @(posedge sda_line) begin
        if (rst_n && scl_line === 1'b1) stops++;
    end

    // Slave: capture each bit on the SCL rising edge.
    always @(posedge scl_line) begin
        if (rst_n) begin
            slv_cnt++;
            if (slv_cnt <= 8)                      got_abyte = {got_abyte[6:0], sda_line};
            else if (slv_cnt >= 10 && slv_cnt <= 17) got_dbyte = {got_dbyte[6:0], sda_line};
            else if (slv_cnt == 18)                got_mack = sda_line;
        end
    end

    // Slave: drive acknowledges and read data while SCL is low.
    always @(negedge scl_line) begin
        if (rst_n) begin
            if (slv_cnt == 8) begin
                slv_sel = (got_abyte[7:1] == slv_addr) && slv_ack_addr_en;
                slv_pull = slv_sel;
            end else if (slv_cnt >= 9 && slv_cnt <= 16 && slv_sel && got_abyte[0]) begin
                slv_pull = !slv_tx[16 - slv_cnt];
            end else if (slv_cnt == 17 && slv_sel && !got_abyte[0]) begin
                slv_pull = slv_ack_data_en;
            end else begin
                slv_pull = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_go(input logic [6:0] a, input logic rd, input logic [7:0] wd);
        @(negedge clk);
        cmd_addr = a;
        cmd_rd = rd;
        cmd_wdata = wd;
        cmd_go = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int seen = 0;
        for (int i = 0; i < 10000 && seen == 0; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        chk(req, seen, 1);
        @(negedge clk);
        chk({req, " done one cycle"}, done, 0);
    endtask

    task automatic t_reset();
        chk("R1 scl released", scl_drive_low, 0);
        chk("R1 sda released", sda_drive_low, 0);
        chk("R9 busy", busy, 0);
        chk("R9 done", done, 0);
        chk("R9 nack", nack, 0);
    endtask

    task automatic t_write_timing();
        time t0, t1, t2;
        int s0 = starts;
        int p0 = stops;
        slv_ack_addr_en = 1'b1;
        slv_ack_data_en = 1'b1;
        pulse_go(7'h5A, 1'b0, 8'hC3);
        chk("R9 busy after go", busy, 1);
        @(posedge scl_line); t0 = $time;
        @(negedge scl_line); t1 = $time;
        @(posedge scl_line); t2 = $time;
        chk("R5 scl high time", 32'(t1 - t0), 32'(2 * QUARTER * TCLK));
        chk("R5 scl period", 32'(t2 - t0), 32'(4 * QUARTER * TCLK));
        wait_done("R9 write done");
        chk("R2 address byte", got_abyte, 8'hB4);
        chk("R2 data byte", got_dbyte, 8'hC3);
        chk("R3 one start", starts - s0, 1);
        chk("R3 one stop", stops - p0, 1);
        chk("R2 scl rises", slv_cnt, 19);
        chk("R7 nack clear", nack, 0);
        chk("R1 released after", {scl_drive_low, sda_drive_low}, 0);
    endtask

    task automatic t_read();
        slv_tx = 8'h96;
        pulse_go(7'h5A, 1'b1, 8'h00);
        wait_done("R9 read done");
        chk("R2 read address byte", got_abyte, 8'hB5);
        chk("R8 rd_data", rd_data, 8'h96);
        chk("R8 final not-ack", got_mack, 1);
        chk("R8 nack clear", nack, 0);
    endtask

    task automatic t_addr_nack();
        int p0 = stops;
        pulse_go(7'h11, 1'b1, 8'h00);
        wait_done("R6 done");
        chk("R6 nack set", nack, 1);
        chk("R6 no data clocks", slv_cnt, 10);
        chk("R6 stop", stops - p0, 1);
        chk("R8 rd_data kept", rd_data, 8'h96);
        repeat (50) @(negedge clk);
        chk("R9 nack held", nack, 1);
    endtask

    task automatic t_data_nack();
        slv_ack_data_en = 1'b0;
        pulse_go(7'h5A, 1'b0, 8'h00);
        wait_done("R7 done");
        chk("R7 nack set", nack, 1);
        chk("R7 data byte", got_dbyte, 8'h00);
        chk("R8 rd_data kept on write", rd_data, 8'h96);
        slv_ack_data_en = 1'b1;
    endtask

    task automatic t_edge_pattern();
        slv_addr = 7'h7F;
        pulse_go(7'h7F, 1'b0, 8'hFF);
        chk("R9 nack cleared by go", nack, 0);
        wait_done("R2 pattern done");
        chk("R2 address all ones", got_abyte, 8'hFE);
        chk("R2 data all ones", got_dbyte, 8'hFF);
        slv_addr = 7'h5A;
    endtask

    task automatic t_go_busy();
        int s0 = starts;
        pulse_go(7'h22, 1'b0, 8'h3C);
        slv_addr = 7'h22;
        repeat (300) @(negedge clk);
        pulse_go(7'h55, 1'b1, 8'hAA);
        wait_done("R10 done");
        chk("R10 first address kept", got_abyte, 8'h44);
        chk("R10 first data kept", got_dbyte, 8'h3C);
        repeat (3000) @(negedge clk);
        chk("R10 no second start", starts - s0, 1);
        chk("R10 idle", busy, 0);
        slv_addr = 7'h5A;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_write_timing();
        t_read();
        t_addr_nack();
        t_data_nack();
        t_edge_pattern();
        t_go_busy();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule